// File: doc/BRIEF.md
# Page-Table Entry Permission Checker

This block decides whether one page-table entry allows a memory access. It reads the 8-bit attribute byte of the entry, the kind of access, the effective privilege, a flag that lets execute-only pages be read, and a flag that lets supervisor code touch user pages. From these it reports whether the entry is malformed, whether it points to a further table level, and whether the access is allowed. It also reports whether the accessed or dirty bits still need setting, and gives the attribute byte with those bits set.

A separate fault input says whether a translation failure came from a memory access fault while reading an entry, or from any other cause. Together with the access kind, it selects a 4-bit exception cause. Every result is combinational, except for one output. A privilege value other than user or supervisor is illegal. It blocks the permission result at once and raises an error flag that is registered one cycle later. Memory traffic and the walk itself are left to the surrounding logic.

Top module: `pte_perm_check`

## Requirements
- R1: The attribute byte holds V at bit 0, R at 1, W at 2, X at 3, U at 4, G at 5, A at 6 and D at 7. `pteInvalid` is high when V is 0, or when W is 1 while R is 0.
- R2: `pteIsPointer` is high exactly when R, W and X are all 0.
- R3: With `privMode`=0 (user), the access type encoding is 0 read, 1 write, 2 read-modify-write and 3 execute. Every access needs U=1. A read needs R, or X with `mxrEn`. A write needs W. A read-modify-write needs W and the read condition. An execute needs X.
- R4: With `privMode`=1 (supervisor), the three data accesses need U=0 or `sumEn`=1, plus the same R/W/X conditions as in R3. An execute needs U=0 and X=1, whatever `sumEn` is.
- R5: When `privMode` is 2 or 3 (illegal), `accessOk` is low.
- R6: `privError` is low after reset. After each rising clock edge it shows whether the `privMode` present at that edge was illegal.
- R7: `needUpdate` is high when A is 0, or when the access is a write or read-modify-write and D is 0.
- R8: `attrNext` equals the input byte with A (bit 6) set. For write and read-modify-write it also has D (bit 7) set. All other bits are unchanged.
- R9: `excCause` is an access-fault code when `faultIsAccess` is 1, and a page-fault code otherwise. The codes are 1 and 12 for execute, 5 and 13 for read, and 7 and 15 for write and read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag |
| rstN | input | 1 | Active-low asynchronous reset |
| pteAttr | input | 8 | Attribute byte of the entry |
| accType | input | 2 | Access kind: 0 read, 1 write, 2 read-modify-write, 3 execute |
| privMode | input | 2 | Effective privilege: 0 user, 1 supervisor, others illegal |
| mxrEn | input | 1 | Execute-only pages may be read |
| sumEn | input | 1 | Supervisor may access user pages |
| faultIsAccess | input | 1 | Failure was an access fault on an entry read |
| pteInvalid | output | 1 | Entry is malformed |
| pteIsPointer | output | 1 | Entry points to the next level |
| accessOk | output | 1 | Access is permitted |
| needUpdate | output | 1 | Accessed or dirty bit must be set |
| attrNext | output | 8 | Attribute byte after the update |
| excCause | output | 4 | Exception cause code |
| privError | output | 1 | Registered illegal-privilege flag |

## Verification
Every output except `privError` is combinational. The bench checks these outputs 1 ns after it drives each vector on a falling clock edge, well before the next rising edge. `privError` is due one rising edge after the vector that caused it. The bench therefore checks it at the following falling edge, against the privilege value it applied one vector earlier, and only then drives new inputs. Because each vector stays in place for a full clock cycle, both timings hold across the whole sweep of attribute bytes, access kinds, privilege values, flags and fault kinds.

// File: rtl/pte_pkg.sv
package pte_pkg;
  localparam int ATTR_W  = 8;
  localparam int CAUSE_W = 4;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RMW   = 2'd2,
    ACC_EXEC  = 2'd3
  } accKind_e;

  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;

  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_ACC  = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_ACC   = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_ACC  = 4'd7;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PAGE = 4'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PAGE  = 4'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_PAGE = 4'd15;

  typedef struct packed {
    logic isUser;
    logic illegal;
    logic wantRead;
    logic wantWrite;
    logic isExec;
  } ctlStrobes_t;
endpackage

// File: rtl/pte_ctl.sv
module pte_ctl
  import pte_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  accType,
  input  logic [1:0]  privMode,
  output ctlStrobes_t strb,
  output logic        privError
);
  accKind_e kind;

  always_comb begin
    kind           = accKind_e'(accType);
    strb.isUser    = (privMode == PRIV_USER);
    strb.illegal   = (privMode != PRIV_USER) && (privMode != PRIV_SUPER);
    strb.wantRead  = (kind == ACC_READ) || (kind == ACC_RMW);
    strb.wantWrite = (kind == ACC_WRITE) || (kind == ACC_RMW);
    strb.isExec    = (kind == ACC_EXEC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privError <= 1'b0;
    else       privError <= strb.illegal;
  end

  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    strb.illegal |=> privError);  // R6
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.illegal |=> !privError);  // R6
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.isExec, strb.wantWrite && !strb.wantRead,
              strb.wantRead && !strb.wantWrite}));  // R3
endmodule

// File: rtl/pte_datapath.sv
module pte_datapath
  import pte_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [ATTR_W-1:0]  pteAttr,
  input  logic               mxrEn,
  input  logic               sumEn,
  input  logic               faultIsAccess,
  output logic               pteInvalid,
  output logic               pteIsPointer,
  output logic               accessOk,
  output logic               needUpdate,
  output logic [ATTR_W-1:0]  attrNext,
  output logic [CAUSE_W-1:0] excCause
);
  logic vBit, rBit, wBit, xBit, uBit, aBit, dBit;
  logic readable, dataOk, userOk, superOk;
  logic [ATTR_W-1:0] setMask;

  assign vBit = pteAttr[BIT_V];
  assign rBit = pteAttr[BIT_R];
  assign wBit = pteAttr[BIT_W];
  assign xBit = pteAttr[BIT_X];
  assign uBit = pteAttr[BIT_U];
  assign aBit = pteAttr[BIT_A];
  assign dBit = pteAttr[BIT_D];

  always_comb begin
    pteInvalid   = !vBit || (wBit && !rBit);
    pteIsPointer = !(rBit || wBit || xBit);

    readable = rBit || (xBit && mxrEn);
    dataOk   = (!strb.wantRead || readable) && (!strb.wantWrite || wBit);
    userOk   = uBit && (strb.isExec ? xBit : dataOk);
    superOk  = strb.isExec ? (!uBit && xBit) : ((!uBit || sumEn) && dataOk);
    accessOk = !strb.illegal && (strb.isUser ? userOk : superOk);

    needUpdate = !aBit || (strb.wantWrite && !dBit);
    setMask          = '0;
    setMask[BIT_A]   = 1'b1;
    setMask[BIT_D]   = strb.wantWrite;
    attrNext         = pteAttr | setMask;

    if (strb.isExec)
      excCause = faultIsAccess ? CAUSE_FETCH_ACC : CAUSE_FETCH_PAGE;
    else if (strb.wantWrite)
      excCause = faultIsAccess ? CAUSE_STORE_ACC : CAUSE_STORE_PAGE;
    else
      excCause = faultIsAccess ? CAUSE_LOAD_ACC : CAUSE_LOAD_PAGE;
  end

  AST_ILLEGAL_DENIED: assert property (@(posedge clk) disable iff (!rstN)
    strb.illegal |-> !accessOk);  // R5
  AST_USER_NEEDS_U: assert property (@(posedge clk) disable iff (!rstN)
    (strb.isUser && accessOk) |-> uBit);  // R3
  AST_SUPER_EXEC_NO_U: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.isUser && strb.isExec && accessOk) |-> (!uBit && xBit));  // R4
  AST_NEXT_HAS_A: assert property (@(posedge clk) disable iff (!rstN)
    attrNext[BIT_A] && (attrNext[5:0] == pteAttr[5:0]));  // R8
  AST_NO_UPDATE_SAME: assert property (@(posedge clk) disable iff (!rstN)
    !needUpdate |-> (attrNext == pteAttr));  // R7
  AST_POINTER_LEGAL_V: assert property (@(posedge clk) disable iff (!rstN)
    (pteIsPointer && vBit) |-> !pteInvalid);  // R2
endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
  import pte_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   pteAttr,
  input  logic [1:0]   accType,
  input  logic [1:0]   privMode,
  input  logic         mxrEn,
  input  logic         sumEn,
  input  logic         faultIsAccess,
  output logic         pteInvalid,
  output logic         pteIsPointer,
  output logic         accessOk,
  output logic         needUpdate,
  output logic [7:0]   attrNext,
  output logic [3:0]   excCause,
  output logic         privError
);
  ctlStrobes_t strb;

  pte_ctl uCtl (
    .clk(clk), .rstN(rstN), .accType(accType), .privMode(privMode),
    .strb(strb), .privError(privError)
  );

  pte_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pteAttr(pteAttr),
    .mxrEn(mxrEn), .sumEn(sumEn), .faultIsAccess(faultIsAccess),
    .pteInvalid(pteInvalid), .pteIsPointer(pteIsPointer),
    .accessOk(accessOk), .needUpdate(needUpdate),
    .attrNext(attrNext), .excCause(excCause)
  );
endmodule

// File: tb/tb_pte_perm_check.sv
`timescale 1ns/1ps
module tb_pte_perm_check;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pteAttr = '0;
  logic [1:0] accType = '0;
  logic [1:0] privMode = '0;
  logic mxrEn = 1'b0, sumEn = 1'b0, faultIsAccess = 1'b0;
  logic pteInvalid, pteIsPointer, accessOk, needUpdate, privError;
  logic [7:0] attrNext;
  logic [3:0] excCause;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pte_perm_check dut (
    .clk(clk), .rstN(rstN), .pteAttr(pteAttr), .accType(accType),
    .privMode(privMode), .mxrEn(mxrEn), .sumEn(sumEn),
    .faultIsAccess(faultIsAccess), .pteInvalid(pteInvalid),
    .pteIsPointer(pteIsPointer), .accessOk(accessOk),
    .needUpdate(needUpdate), .attrNext(attrNext), .excCause(excCause),
    .privError(privError)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails < 30) $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit modelOk(input logic [7:0] a, input int acc,
                                 input int pv, input bit mxr, input bit sum);
    bit r, w, x, u, rd;
    r = a[1]; w = a[2]; x = a[3]; u = a[4];
    rd = r || (x && mxr);
    if (pv == 0) begin
      case (acc)
        0: return u && rd;
        1: return u && w;
        2: return u && w && rd;
        default: return u && x;
      endcase
    end else if (pv == 1) begin
      case (acc)
        0: return (!u || sum) && rd;
        1: return (!u || sum) && w;
        2: return (!u || sum) && w && rd;
        default: return !u && x;
      endcase
    end
    return 1'b0;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit lastIll;
    repeat (3) @(negedge clk);
    check("R6 reset", int'(privError), 0);
    rstN = 1'b1;
    lastIll = 1'b0;
    for (int pv = 0; pv < 4; pv++)
      for (int acc = 0; acc < 4; acc++)
        for (int fl = 0; fl < 8; fl++)
          for (int a = 0; a < 256; a++) begin
            bit store, ill, expUpd;
            logic [7:0] ab, expNext;
            int expCause;
            @(negedge clk);
            check("R6 registered flag", int'(privError), int'(lastIll));
            ab = a[7:0];
            pteAttr = ab; accType = acc[1:0]; privMode = pv[1:0];
            mxrEn = fl[0]; sumEn = fl[1]; faultIsAccess = fl[2];
            #1;
            store = (acc == 1) || (acc == 2);
            ill = (pv > 1);
            check("R1 invalid", int'(pteInvalid), int'(!ab[0] || (ab[2] && !ab[1])));
            check("R2 pointer", int'(pteIsPointer), int'(ab[3:1] == 3'b000));
            if (ill) check("R5 illegal denies", int'(accessOk), 0);
            else if (pv == 0) check("R3 user perm", int'(accessOk),
                                    int'(modelOk(ab, acc, pv, fl[0], fl[1])));
            else check("R4 super perm", int'(accessOk),
                       int'(modelOk(ab, acc, pv, fl[0], fl[1])));
            expUpd = !ab[6] || (store && !ab[7]);
            check("R7 update", int'(needUpdate), int'(expUpd));
            expNext = ab | 8'h40 | (store ? 8'h80 : 8'h00);
            check("R8 next attr", int'(attrNext), int'(expNext));
            if (acc == 3) expCause = fl[2] ? 1 : 12;
            else if (store) expCause = fl[2] ? 7 : 15;
            else expCause = fl[2] ? 5 : 13;
            check("R9 cause", int'(excCause), expCause);
            lastIll = ill;
          end
    @(negedge clk);
    check("R6 registered flag final", int'(privError), int'(lastIll));
    privMode = 2'd0;
    @(negedge clk);
    check("R6 flag clears", int'(privError), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule